// File: doc/BRIEF.md
# Storage-to-Storage String Operation Engine

This block carries out one memory-to-memory character string instruction at a time. Each operand address is built from the contents of a base register plus an unsigned 12-bit displacement, wrapped to 24 bits. The engine then walks both strings one byte at a time, from the lowest address upward, through a byte-wide memory port. It uses a request/ready handshake on that port and makes at most one access per cycle.

Two operations are supported. A move copies the second string onto the first. A compare reads both strings, stops at the first byte that differs, and reports a 2-bit condition code. The instruction arrives already decoded, with a start pulse. The base registers are read through a single combinational read port that the engine drives in turn for each operand. A busy flag covers the whole operation.

Top module: `strop_engine`

## Requirements
- R1: While reset is low and in the cycle after it, busy is 0, mem_req is 0 and cc is 0.
- R2: start is accepted only while busy is 0; a start pulse raised while busy is 1 has no effect on the running operation or on any later access.
- R3: The first operand address is the content of the base register selected by base1_sel plus disp1 zero-extended; the second uses base2_sel and disp2 the same way. The base register port is read for the first operand and then for the second.
- R4: len_code holds the byte count minus one: 0 processes one byte and 255 processes 256 bytes.
- R5: Move (op_code 0): for k from 0 upward, the byte at second address + k is read and then written to first address + k. An overlapping destination therefore sees bytes written earlier in the same operation. A move makes exactly 2 accesses and 1 write per byte.
- R6: Compare (op_code 1): for each k, the first operand byte is read and then the second. The operation stops after the first pair that differs. cc becomes 0 when all bytes are equal, 1 when the first operand byte is lower (unsigned), and 2 when it is higher. A compare performs no writes, and cc never takes the value 3.
- R7: A move leaves cc unchanged.
- R8: While mem_req is 1 and mem_ready is 0, mem_req, mem_addr, mem_we and mem_wdata hold their values into the next cycle.
- R9: busy rises in the cycle after an accepted start and stays 1 until the last access of the operation completes. No memory request is made while busy is 0.
- R10: Operand addresses and the per-byte address stepping wrap modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op_code | input | 1 | 0 = move, 1 = compare |
| len_code | input | 8 | Byte count minus one |
| base1_sel | input | 4 | Base register for the first operand |
| disp1 | input | 12 | Displacement of the first operand |
| base2_sel | input | 4 | Base register for the second operand |
| disp2 | input | 12 | Displacement of the second operand |
| breg_idx | output | 4 | Base register read index |
| breg_data | input | 24 | Base register read data (same cycle) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid when mem_ready is 1 |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Operation in progress |
| cc | output | 2 | Condition code from the last compare |

## Verification
The assertions assume the following about the inputs. The base register port returns data in the same cycle as the index. mem_rdata is valid in any cycle in which mem_ready is 1. mem_ready may be held low for any number of cycles. The bench drives mem_ready from $urandom on every falling edge, whether or not a request is pending, so stalls of varying length occur inside every operation. It also sets mem_rdata from its own memory model at the address currently on the port. Start pulses are raised only at falling edges, and one directed case raises a second start in the middle of a busy operation.

// File: rtl/strop_pkg.sv
// Shared types for the string operation engine.
// Assumes: no other package defines these names.
package strop_pkg;

    // Sequencer states, one per kind of cycle the engine spends.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE1,
        ST_BASE2,
        ST_RD1,
        ST_RD2,
        ST_WR1
    } seq_state_t;

    // Operation selector as it arrives on op_code.
    typedef enum logic {
        OP_MOVE = 1'b0,
        OP_CMP  = 1'b1
    } str_op_t;

    // Condition code values reported after a compare.
    localparam logic [1:0] CC_EQUAL      = 2'd0;
    localparam logic [1:0] CC_FIRST_LOW  = 2'd1;
    localparam logic [1:0] CC_FIRST_HIGH = 2'd2;

endpackage

// File: rtl/strop_agen.sv
// Address generator: forms the two operand start addresses
// (base + zero-extended displacement, wrapped to ADDR_W) and keeps a shared
// byte offset that is added to both.
// Assumes: load1/load2 are pulsed with base_in/disp_in valid in that cycle.
module strop_agen #(
    parameter int ADDR_W = 24,
    parameter int DISP_W = 12,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load1,
    input  logic              load2,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [DISP_W-1:0] disp_in,
    input  logic              clr_ofs,
    input  logic              step,
    output logic [ADDR_W-1:0] addr1,
    output logic [ADDR_W-1:0] addr2,
    output logic [LEN_W-1:0]  ofs
);
    localparam int PAD_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] start1_q, start2_q, eff_addr;
    logic [LEN_W-1:0]  ofs_q;

    // Effective address of the operand being loaded.
    always_comb begin
        eff_addr = base_in + {{PAD_W{1'b0}}, disp_in};
    end

    // Capture the operand start addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start1_q <= '0;
            start2_q <= '0;
        end else begin
            if (load1) start1_q <= eff_addr;
            if (load2) start2_q <= eff_addr;
        end
    end

    // Byte offset shared by both strings.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_ofs) ofs_q <= '0;
        else if (step)         ofs_q <= ofs_q + 1'b1;
    end

    // Current byte addresses, wrapping modulo 2^ADDR_W.
    always_comb begin
        addr1 = start1_q + ADDR_W'(ofs_q);
        addr2 = start2_q + ADDR_W'(ofs_q);
        ofs   = ofs_q;
    end

endmodule

// File: rtl/strop_cmp.sv
// Unsigned byte comparator producing the condition code for a pair of bytes.
// Assumes: a is the first operand byte, b is the second.
module strop_cmp
    import strop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              same,
    output logic [1:0]        code
);
    // Classify the pair as equal, first low or first high.
    always_comb begin
        same = (a == b);
        if (same)       code = CC_EQUAL;
        else if (a < b) code = CC_FIRST_LOW;
        else            code = CC_FIRST_HIGH;
    end

endmodule

// File: rtl/strop_seq.sv
// Sequencer: latches the instruction on an idle start, reads both base
// registers, then loops over the bytes issuing one memory access at a time.
// Move: read second, write first. Compare: read first, read second, test.
// Assumes: the base register port answers combinationally, and mem_rdata is
// valid whenever mem_ready is high.
module strop_seq
    import strop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    parameter int DISP_W = 12,
    parameter int RIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [RIDX_W-1:0] b1_in,
    input  logic [DISP_W-1:0] d1_in,
    input  logic [RIDX_W-1:0] b2_in,
    input  logic [DISP_W-1:0] d2_in,
    output logic [RIDX_W-1:0] breg_idx,
    output logic [DISP_W-1:0] disp_out,
    output logic              load1,
    output logic              load2,
    output logic              clr_ofs,
    output logic              step,
    input  logic [LEN_W-1:0]  ofs_in,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              addr_sel,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] cmp_a,
    input  logic              cmp_same,
    input  logic [1:0]        cmp_code,
    output logic              busy,
    output logic [1:0]        cc,
    output logic              op_is_cmp
);
    seq_state_t        state_q, state_d;
    str_op_t           op_q;
    logic [LEN_W-1:0]  len_q;
    logic [RIDX_W-1:0] b1_q, b2_q;
    logic [DISP_W-1:0] d1_q, d2_q;
    logic [DATA_W-1:0] hold_q;
    logic [1:0]        cc_q;
    logic              start_ok, last, cmp_stop;

    // Control conditions derived from the current state.
    always_comb begin
        start_ok = start && (state_q == ST_IDLE);
        last     = (ofs_in == len_q);
        cmp_stop = !cmp_same || last;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Instruction latch, loaded only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_MOVE;
            len_q <= '0;
            b1_q <= '0;
            b2_q <= '0;
            d1_q <= '0;
            d2_q <= '0;
        end else if (start_ok) begin
            op_q <= str_op_t'(op_in);
            len_q <= len_in;
            b1_q <= b1_in;
            b2_q <= b2_in;
            d1_q <= d1_in;
            d2_q <= d2_in;
        end
    end

    // Byte holding register: first byte for compare, source byte for move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (mem_ready) begin
            if (state_q == ST_RD1)
                hold_q <= mem_rdata;
            else if (state_q == ST_RD2 && op_q == OP_MOVE)
                hold_q <= mem_rdata;
        end
    end

    // Condition code, updated only when a compare finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cc_q <= CC_EQUAL;
        else if (state_q == ST_RD2 && mem_ready && op_q == OP_CMP && cmp_stop)
            cc_q <= cmp_code;
    end

    // Next state and per-cycle controls.
    always_comb begin
        state_d  = state_q;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        addr_sel = 1'b0;
        load1    = 1'b0;
        load2    = 1'b0;
        clr_ofs  = 1'b0;
        step     = 1'b0;
        breg_idx = b1_q;
        disp_out = d1_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) state_d = ST_BASE1;
            end
            ST_BASE1: begin
                load1   = 1'b1;
                clr_ofs = 1'b1;
                state_d = ST_BASE2;
            end
            ST_BASE2: begin
                breg_idx = b2_q;
                disp_out = d2_q;
                load2    = 1'b1;
                state_d  = (op_q == OP_CMP) ? ST_RD1 : ST_RD2;
            end
            ST_RD1: begin
                mem_req = 1'b1;
                if (mem_ready) state_d = ST_RD2;
            end
            ST_RD2: begin
                mem_req  = 1'b1;
                addr_sel = 1'b1;
                if (mem_ready) begin
                    if (op_q == OP_MOVE) begin
                        state_d = ST_WR1;
                    end else if (cmp_stop) begin
                        state_d = ST_IDLE;
                    end else begin
                        step    = 1'b1;
                        state_d = ST_RD1;
                    end
                end
            end
            ST_WR1: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    if (last) begin
                        state_d = ST_IDLE;
                    end else begin
                        step    = 1'b1;
                        state_d = ST_RD2;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs taken from registered state.
    always_comb begin
        mem_wdata = hold_q;
        cmp_a     = hold_q;
        busy      = (state_q != ST_IDLE);
        cc        = cc_q;
        op_is_cmp = (op_q == OP_CMP);
    end

endmodule

// File: rtl/strop_engine.sv
// Top of the string operation engine: ties the sequencer, the address
// generator and the byte comparator together and selects the port address.
// Assumes: a single-cycle combinational base register read port.
module strop_engine #(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 8,
    parameter int DISP_W   = 12,
    parameter int NUM_REGS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        op_code,
    input  logic [LEN_W-1:0]            len_code,
    input  logic [$clog2(NUM_REGS)-1:0] base1_sel,
    input  logic [DISP_W-1:0]           disp1,
    input  logic [$clog2(NUM_REGS)-1:0] base2_sel,
    input  logic [DISP_W-1:0]           disp2,
    output logic [$clog2(NUM_REGS)-1:0] breg_idx,
    input  logic [ADDR_W-1:0]           breg_data,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [DATA_W-1:0]           mem_rdata,
    input  logic                        mem_ready,
    output logic                        busy,
    output logic [1:0]                  cc
);
    localparam int RIDX_W = $clog2(NUM_REGS);

    logic [DISP_W-1:0] disp_sel;
    logic              load1, load2, clr_ofs, step, addr_sel;
    logic [LEN_W-1:0]  ofs;
    logic [ADDR_W-1:0] addr1, addr2;
    logic [DATA_W-1:0] cmp_a;
    logic              cmp_same, op_is_cmp;
    logic [1:0]        cmp_code;

    strop_seq #(
        .DATA_W(DATA_W), .LEN_W(LEN_W), .DISP_W(DISP_W), .RIDX_W(RIDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_code),
        .len_in(len_code), .b1_in(base1_sel), .d1_in(disp1),
        .b2_in(base2_sel), .d2_in(disp2), .breg_idx(breg_idx),
        .disp_out(disp_sel), .load1(load1), .load2(load2),
        .clr_ofs(clr_ofs), .step(step), .ofs_in(ofs),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .addr_sel(addr_sel), .mem_wdata(mem_wdata),
        .cmp_a(cmp_a), .cmp_same(cmp_same), .cmp_code(cmp_code),
        .busy(busy), .cc(cc), .op_is_cmp(op_is_cmp)
    );

    strop_agen #(
        .ADDR_W(ADDR_W), .DISP_W(DISP_W), .LEN_W(LEN_W)
    ) u_agen (
        .clk(clk), .rst_n(rst_n), .load1(load1), .load2(load2),
        .base_in(breg_data), .disp_in(disp_sel), .clr_ofs(clr_ofs),
        .step(step), .addr1(addr1), .addr2(addr2), .ofs(ofs)
    );

    strop_cmp #(
        .DATA_W(DATA_W)
    ) u_cmp (
        .a(cmp_a), .b(mem_rdata), .same(cmp_same), .code(cmp_code)
    );

    // Port address: first operand unless the sequencer selects the second.
    always_comb begin
        mem_addr = addr_sel ? addr2 : addr1;
    end

endmodule

// File: rtl/strop_engine_chk.sv
// Protocol and result checker for strop_engine, attached by bind.
// Assumes: it sees the top's ports plus the latched operation kind.
module strop_engine_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [1:0]        cc,
    input logic              op_is_cmp
);
    // R1: reset clears busy, request and condition code.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req && cc == 2'b00));

    // R8: a stalled request holds all its fields.
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

    // R9: no memory traffic while idle.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R9: an idle start raises busy on the next cycle.
    assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6: a compare never writes memory.
    assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_is_cmp) |-> !(mem_req && mem_we));

    // R6: the code 3 is never produced.
    assert_cc_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cc != 2'b11);

    // R7: a move leaves the condition code alone.
    assert_move_keeps_cc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_is_cmp) |=> $stable(cc));

endmodule

bind strop_engine strop_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cc(cc), .op_is_cmp(op_is_cmp)
);

// File: tb/test_strop_engine.sv
// Bench for strop_engine: seeded random operations plus directed corners,
// checked against a byte-level memory model held in the bench.
module test_strop_engine;
    localparam int CLK_PERIOD = 10;
    localparam int OP_TIMEOUT = 20000;
    localparam int RUN_LIMIT  = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_code = 1'b0;
    logic [7:0]  len_code = '0;
    logic [3:0]  base1_sel = '0, base2_sel = '0;
    logic [11:0] disp1 = '0, disp2 = '0;
    logic [3:0]  breg_idx;
    logic [23:0] breg_data;
    logic        mem_req, mem_we, busy;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [1:0]  cc;

    logic [23:0] regs [16];
    logic [7:0]  dut_mem [int];
    logic [7:0]  ref_mem [int];
    int n_chk = 0, n_bad = 0, acc_cnt = 0, wr_cnt = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign breg_data = regs[breg_idx];

    strop_engine i_strop_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .len_code(len_code), .base1_sel(base1_sel), .disp1(disp1),
        .base2_sel(base2_sel), .disp2(disp2), .breg_idx(breg_idx),
        .breg_data(breg_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .cc(cc)
    );

    function automatic logic [7:0] seed_byte(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ (a[23:16] + 8'h3C);
    endfunction

    function automatic logic [7:0] dut_rd(logic [23:0] a);
        if (dut_mem.exists(int'(a))) return dut_mem[int'(a)];
        return seed_byte(a);
    endfunction

    function automatic logic [7:0] ref_rd(logic [23:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return seed_byte(a);
    endfunction

    task automatic poke(logic [23:0] a, logic [7:0] v);
        dut_mem[int'(a)] = v;
        ref_mem[int'(a)] = v;
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Memory responder: random ready, read data for the current address.
    always @(negedge clk) begin
        mem_ready <= (($urandom % 10) < 7);
        mem_rdata <= dut_rd(mem_addr);
    end

    // Count completed accesses and apply writes.
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            acc_cnt++;
            if (mem_we) begin
                wr_cnt++;
                dut_mem[int'(mem_addr)] = mem_wdata;
            end
        end
    end

    // Watchdog for the whole run.
    always @(posedge clk) begin
        cyc++;
        if (cyc > RUN_LIMIT) begin
            n_bad++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, RUN_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic do_op(bit op, logic [7:0] len, logic [3:0] b1, logic [11:0] d1,
                         logic [3:0] b2, logic [11:0] d2, bit disturb);
        logic [23:0] a1 = regs[b1] + {12'h000, d1};
        logic [23:0] a2 = regs[b2] + {12'h000, d2};
        int n = int'(len) + 1;
        int exp_acc = 2 * n;
        int exp_wr = 0;
        int acc0, wr0, t;
        logic [1:0] exp_cc = cc;
        if (!op) begin
            exp_wr = n;
            for (int k = 0; k < n; k++)
                ref_mem[int'(a1 + 24'(k))] = ref_rd(a2 + 24'(k));
        end else begin
            exp_cc = 2'd0;
            for (int k = 0; k < n; k++) begin
                logic [7:0] x = ref_rd(a1 + 24'(k));
                logic [7:0] y = ref_rd(a2 + 24'(k));
                if (x != y) begin
                    exp_cc = (x < y) ? 2'd1 : 2'd2;
                    exp_acc = 2 * (k + 1);
                    break;
                end
            end
        end
        acc0 = acc_cnt;
        wr0 = wr_cnt;
        @(negedge clk);
        op_code = op; len_code = len;
        base1_sel = b1; disp1 = d1; base2_sel = b2; disp2 = d2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        if (disturb) begin
            repeat (3) @(negedge clk);
            op_code = ~op; len_code = 8'hFF;
            base1_sel = b2; disp1 = d2 + 12'h123; base2_sel = b1; disp2 = d1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (busy && t < OP_TIMEOUT) begin
            @(negedge clk);
            t++;
        end
        check(t < OP_TIMEOUT, "R9 busy release", t, OP_TIMEOUT);
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R2 idle after op", busy, 0);
        if (op) check(cc == exp_cc, "R6 condition code", cc, exp_cc);
        else    check(cc == exp_cc, "R7 cc kept by move", cc, exp_cc);
        check(acc_cnt - acc0 == exp_acc, op ? "R6 access count" : "R5 access count",
              acc_cnt - acc0, exp_acc);
        check(wr_cnt - wr0 == exp_wr, op ? "R6 no writes" : "R5 write count",
              wr_cnt - wr0, exp_wr);
        if (!op) begin
            int bad = 0;
            for (int k = 0; k < n; k++)
                if (dut_rd(a1 + 24'(k)) !== ref_rd(a1 + 24'(k))) bad++;
            check(bad == 0, "R5 R3 destination bytes", bad, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) regs[i] = 24'(i * 24'h010101);
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(busy == 1'b0, "R1 busy at reset", busy, 0);
        check(mem_req == 1'b0, "R1 mem_req at reset", mem_req, 0);
        check(cc == 2'd0, "R1 cc at reset", cc, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: one-byte move and 256-byte move.
        regs[1] = 24'h001000; regs[2] = 24'h002000;
        do_op(1'b0, 8'd0, 4'd1, 12'h004, 4'd2, 12'h008, 1'b0);
        do_op(1'b0, 8'd255, 4'd1, 12'h100, 4'd2, 12'h300, 1'b0);

        // R5: overlapping move propagates the first byte.
        regs[3] = 24'h004000;
        poke(24'h004000, 8'hA7);
        do_op(1'b0, 8'd9, 4'd3, 12'h001, 4'd3, 12'h000, 1'b0);
        check(dut_rd(24'h00400A) == 8'hA7, "R5 overlap fill", dut_rd(24'h00400A), 8'hA7);

        // R6: equal, first low at start, first high (unsigned) at the end.
        regs[4] = 24'h005000; regs[5] = 24'h006000;
        for (int k = 0; k < 8; k++) begin
            poke(24'h005000 + 24'(k), 8'(k + 8'h40));
            poke(24'h006000 + 24'(k), 8'(k + 8'h40));
        end
        do_op(1'b1, 8'd7, 4'd4, 12'h000, 4'd5, 12'h000, 1'b0);
        poke(24'h005000, 8'h10);
        do_op(1'b1, 8'd7, 4'd4, 12'h000, 4'd5, 12'h000, 1'b0);
        poke(24'h005000, 8'h40);
        poke(24'h005007, 8'h80); poke(24'h006007, 8'h7F);
        do_op(1'b1, 8'd7, 4'd4, 12'h000, 4'd5, 12'h000, 1'b0);

        // R7: a move right after a compare keeps cc = 2.
        do_op(1'b0, 8'd3, 4'd1, 12'h800, 4'd2, 12'h800, 1'b0);

        // R10: both strings cross the top of the address space.
        regs[6] = 24'hFFFFF8; regs[7] = 24'hFFFFFC;
        do_op(1'b0, 8'd15, 4'd6, 12'h004, 4'd7, 12'h000, 1'b0);
        do_op(1'b1, 8'd15, 4'd6, 12'h004, 4'd7, 12'h000, 1'b0);

        // R2: a start raised while busy is ignored.
        do_op(1'b0, 8'd20, 4'd1, 12'hA00, 4'd2, 12'hA40, 1'b1);

        // Random operations mixed with equal-prefix compares.
        for (int it = 0; it < 40; it++) begin
            bit          op = 1'($urandom % 2);
            logic [7:0]  len = 8'($urandom % 32);
            logic [3:0]  b1 = 4'($urandom), b2 = 4'($urandom);
            logic [11:0] d1 = 12'($urandom), d2 = 12'($urandom);
            logic [23:0] a1, a2;
            for (int i = 0; i < 16; i++) regs[i] = 24'($urandom);
            a1 = regs[b1] + {12'h000, d1};
            a2 = regs[b2] + {12'h000, d2};
            if (op && ($urandom % 3 != 0)) begin
                for (int k = 0; k <= int'(len); k++)
                    poke(a1 + 24'(k), ref_rd(a2 + 24'(k)));
                if ($urandom % 2 == 1)
                    poke(a1 + 24'($urandom % (int'(len) + 1)), 8'($urandom));
            end
            do_op(op, len, b1, d1, b2, d2, ($urandom % 8) == 0);
        end

        summary();
        $finish;
    end

endmodule